// File: doc/BRIEF.md
# DTMF Transmit Burst Controller

This block sequences the transmit side of a touch-tone signalling path for a host processor. The host writes a 4-bit key code into the transmit register. In burst mode that single write produces one timed tone burst, followed by a silent gap of the same length. When the gap ends, the block emits a one-cycle transmit-empty event and, if enabled, a one-cycle interrupt event. In non-burst mode no timing is applied: the tone simply follows a host-controlled enable bit, and each write just replaces the stored key code.

Alongside the timing, the block turns the stored key code into a row index and a column index on a 4x4 keypad grid. It also drives two group-enable outputs for an external tone generator, so the host can request the full dual tone or one group alone. Timing is counted in millisecond ticks supplied from outside. Waveform synthesis and digital-to-analog conversion belong to the downstream generator.

Top module: `dtmf_burst_ctrl`

## Requirements
- R1: After reset, toneOn, rowEn, colEn, txEmptyEv and irqEv are all 0.
- R2: With burstOffN = 0, a write while idle turns toneOn on from the next cycle. toneOn stays on for exactly 51 msTick pulses and then stays off for exactly 51 further msTick pulses (the pause).
- R3: If cpMode is 1 at the cycle of the starting write, both the tone and the pause last 102 msTick pulses instead of 51.
- R4: The clock edge that takes the final pause tick raises txEmptyEv for exactly one cycle. irqEv rises in that same cycle only when irqEn was 1 at that edge.
- R5: With burstOffN = 1, toneOn equals toneOut in every cycle and txEmptyEv never rises.
- R6: The burst select is active low: burstOffN = 1 disables burst timing. Raising it during a burst or pause abandons the sequence, with no empty event afterwards.
- R7: In burst mode, a write that arrives during the tone or the pause is ignored. The stored code, and therefore rowIdx/colIdx, stay unchanged, and the tone and pause lengths stay unchanged.
- R8: The stored code maps to a (rowIdx, colIdx) pair as follows. Codes 1 to 9 give row (code-1)/3 and column (code-1)%3. Code 10 gives (3,1), code 11 gives (3,0) and code 12 gives (3,2). Codes 13, 14 and 15 give rows 0, 1 and 2 in column 3. Code 0 gives (3,3).
- R9: With singleSel = 0, rowEn and colEn both equal toneOn. With singleSel = 1, only one group is enabled while toneOn is high: colEn if colSel = 1, rowEn if colSel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Transmit register write strobe |
| wrCode | input | 4 | Key code written |
| msTick | input | 1 | One-cycle millisecond tick |
| burstOffN | input | 1 | 0 = burst mode, 1 = tone follows toneOut |
| cpMode | input | 1 | Doubles burst and pause length |
| toneOut | input | 1 | Tone enable in non-burst mode |
| singleSel | input | 1 | 1 = single group, 0 = dual tone |
| colSel | input | 1 | In single mode: 1 = column group, 0 = row group |
| irqEn | input | 1 | Enables the interrupt event |
| toneOn | output | 1 | Tone is being sent |
| rowEn | output | 1 | Row (low) group enabled |
| colEn | output | 1 | Column (high) group enabled |
| rowIdx | output | 2 | Row index of the stored code |
| colIdx | output | 2 | Column index of the stored code |
| txEmptyEv | output | 1 | One-cycle transmit-empty event |
| irqEv | output | 1 | One-cycle interrupt event |

## Verification
Bursts are started with random codes, random cpMode and random irqEn, and are paced by ticks with random gaps. This separates the 51-tick and 102-tick lengths and shows that counting follows ticks rather than clock cycles. Directed runs add a second write in the middle of the tone and again in the middle of the pause, which shows whether writes are ignored. A mode flip part-way through a burst shows whether the sequence is abandoned. Random non-burst stimulus sweeps toneOut, singleSel, colSel and all sixteen codes, which tells the enable selection and the keypad mapping apart from the burst timing.

// File: rtl/dtmf_burst_pkg.sv
package dtmf_burst_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_TONE  = 2'd1,
    TX_PAUSE = 2'd2
  } tx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture the written code
    logic toneGate;  // tone should sound now
  } tx_ctl_t;

  typedef struct packed {
    logic [1:0] row;
    logic [1:0] col;
  } key_pos_t;

  // 4x4 keypad position of a code (R8)
  function automatic key_pos_t keyPos(input logic [3:0] code);
    key_pos_t p;
    case (code)
      4'd1:  p = '{row: 2'd0, col: 2'd0};
      4'd2:  p = '{row: 2'd0, col: 2'd1};
      4'd3:  p = '{row: 2'd0, col: 2'd2};
      4'd4:  p = '{row: 2'd1, col: 2'd0};
      4'd5:  p = '{row: 2'd1, col: 2'd1};
      4'd6:  p = '{row: 2'd1, col: 2'd2};
      4'd7:  p = '{row: 2'd2, col: 2'd0};
      4'd8:  p = '{row: 2'd2, col: 2'd1};
      4'd9:  p = '{row: 2'd2, col: 2'd2};
      4'd10: p = '{row: 2'd3, col: 2'd1};
      4'd11: p = '{row: 2'd3, col: 2'd0};
      4'd12: p = '{row: 2'd3, col: 2'd2};
      4'd13: p = '{row: 2'd0, col: 2'd3};
      4'd14: p = '{row: 2'd1, col: 2'd3};
      4'd15: p = '{row: 2'd2, col: 2'd3};
      default: p = '{row: 2'd3, col: 2'd3};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dtmf_burst_fsm.sv
module dtmf_burst_fsm
  import dtmf_burst_pkg::*;
#(
  parameter int BURST_TICKS = 51,
  parameter int CP_MULT     = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    msTick,
  input  logic    burstOffN,
  input  logic    cpMode,
  input  logic    toneOut,
  input  logic    irqEn,
  output tx_ctl_t ctl,
  output logic    txEmptyEv,
  output logic    irqEv
);

  localparam int LONG_TICKS = BURST_TICKS * CP_MULT;
  localparam int CNT_W      = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(BURST_TICKS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             longDur;
  logic [CNT_W-1:0] lastCnt;
  logic             atLast;

  assign lastCnt = longDur ? LONG_LAST : SHORT_LAST;
  assign atLast  = msTick && (cnt == lastCnt);

  always_comb begin
    ctl.load     = wrEn && (burstOffN || st == TX_IDLE);
    ctl.toneGate = burstOffN ? toneOut : (st == TX_TONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= TX_IDLE;
      cnt       <= '0;
      longDur   <= 1'b0;
      txEmptyEv <= 1'b0;
      irqEv     <= 1'b0;
    end else begin
      txEmptyEv <= 1'b0;
      irqEv     <= 1'b0;
      if (burstOffN) begin
        st  <= TX_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          TX_IDLE: if (wrEn) begin
            st      <= TX_TONE;
            cnt     <= '0;
            longDur <= cpMode;
          end
          TX_TONE: if (atLast) begin
            st  <= TX_PAUSE;
            cnt <= '0;
          end else if (msTick) begin
            cnt <= cnt + 1'b1;
          end
          TX_PAUSE: if (atLast) begin
            st        <= TX_IDLE;
            cnt       <= '0;
            txEmptyEv <= 1'b1;
            irqEv     <= irqEn;
          end else if (msTick) begin
            cnt <= cnt + 1'b1;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  // R2 / R3: the tick counter never runs past the selected length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st != TX_IDLE) |-> (cnt <= lastCnt));

  // R4: the empty event only follows a pause
  p_empty_after_pause_r4: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyEv |-> ($past(st) == TX_PAUSE));

  // R4: interrupt never without the empty event
  p_irq_with_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqEv |-> txEmptyEv);

  // R5: no empty event while burst timing is off
  p_nonburst_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(burstOffN) |-> !txEmptyEv);

  // R7: a busy sequencer does not accept a new code
  p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!burstOffN && st != TX_IDLE) |-> !ctl.load);

endmodule

// File: rtl/dtmf_tone_path.sv
module dtmf_tone_path
  import dtmf_burst_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tx_ctl_t           ctl,
  input  logic [CODE_W-1:0] wrCode,
  input  logic              singleSel,
  input  logic              colSel,
  output logic              toneOn,
  output logic              rowEn,
  output logic              colEn,
  output logic [1:0]        rowIdx,
  output logic [1:0]        colIdx
);

  logic [CODE_W-1:0] codeReg;
  key_pos_t          pos;

  always_ff @(posedge clk) begin
    if (!rstN)         codeReg <= '0;
    else if (ctl.load) codeReg <= wrCode;
  end

  assign pos    = keyPos(4'(codeReg));
  assign rowIdx = pos.row;
  assign colIdx = pos.col;
  assign toneOn = ctl.toneGate;
  assign rowEn  = ctl.toneGate && (!singleSel || !colSel);
  assign colEn  = ctl.toneGate && (!singleSel || colSel);

  // R7: stored code changes only on an accepted write
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(codeReg));

  // R9: single-tone mode never drives both groups
  p_single_group_r9: assert property (@(posedge clk) disable iff (!rstN)
    singleSel |-> ($countones({rowEn, colEn}) == int'(toneOn)));

endmodule

// File: rtl/dtmf_burst_ctrl.sv
module dtmf_burst_ctrl
  import dtmf_burst_pkg::*;
#(
  parameter int BURST_TICKS = 51,
  parameter int CP_MULT     = 2,
  parameter int CODE_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrCode,
  input  logic              msTick,
  input  logic              burstOffN,
  input  logic              cpMode,
  input  logic              toneOut,
  input  logic              singleSel,
  input  logic              colSel,
  input  logic              irqEn,
  output logic              toneOn,
  output logic              rowEn,
  output logic              colEn,
  output logic [1:0]        rowIdx,
  output logic [1:0]        colIdx,
  output logic              txEmptyEv,
  output logic              irqEv
);

  tx_ctl_t ctl;

  dtmf_burst_fsm #(.BURST_TICKS(BURST_TICKS), .CP_MULT(CP_MULT)) uFsm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .msTick(msTick),
    .burstOffN(burstOffN), .cpMode(cpMode), .toneOut(toneOut),
    .irqEn(irqEn), .ctl(ctl), .txEmptyEv(txEmptyEv), .irqEv(irqEv)
  );

  dtmf_tone_path #(.CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrCode(wrCode),
    .singleSel(singleSel), .colSel(colSel), .toneOn(toneOn),
    .rowEn(rowEn), .colEn(colEn), .rowIdx(rowIdx), .colIdx(colIdx)
  );

endmodule

// File: tb/tb_dtmf_burst_ctrl.sv
module tb_dtmf_burst_ctrl;

  localparam int SHORT_LEN = 51;
  localparam int LONG_LEN  = 102;

  logic clk = 1'b0;
  logic rstN, wrEn, msTick, burstOffN, cpMode, toneOut, singleSel, colSel, irqEn;
  logic [3:0] wrCode;
  logic toneOn, rowEn, colEn, txEmptyEv, irqEv;
  logic [1:0] rowIdx, colIdx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dtmf_burst_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode), .msTick(msTick),
    .burstOffN(burstOffN), .cpMode(cpMode), .toneOut(toneOut),
    .singleSel(singleSel), .colSel(colSel), .irqEn(irqEn),
    .toneOn(toneOn), .rowEn(rowEn), .colEn(colEn), .rowIdx(rowIdx),
    .colIdx(colIdx), .txEmptyEv(txEmptyEv), .irqEv(irqEv)
  );

  function automatic int expRow(input int code);
    if (code >= 1 && code <= 9) return (code - 1) / 3;
    if (code >= 13) return code - 13;
    return 3;
  endfunction

  function automatic int expCol(input int code);
    if (code >= 1 && code <= 9) return (code - 1) % 3;
    if (code == 10) return 1;
    if (code == 11) return 0;
    if (code == 12) return 2;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one tick pulse after a gap; returns at the negedge after the tick edge
  task automatic tick(input int gap);
    repeat (gap) @(negedge clk);
    msTick = 1'b1;
    @(negedge clk);
    msTick = 1'b0;
  endtask

  task automatic writeCode(input int code);
    wrCode = 4'(code);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // full burst; optional intruding write at tick 'midTick' of tone and pause
  task automatic runBurst(input int code, input bit cp, input bit ie,
                          input bit intrude, input int other);
    int len = cp ? LONG_LEN : SHORT_LEN;
    bit toneBad = 0, pauseBad = 0, idxBad = 0;
    cpMode = cp;
    irqEn = ie;
    writeCode(code);
    cpMode = ~cp;  // must not matter after the start
    check(toneOn == 1'b1, cp ? "R3 tone starts" : "R2 tone starts", int'(toneOn), 1);
    check(int'(rowIdx) == expRow(code) && int'(colIdx) == expCol(code),
          "R8 burst code position", int'(rowIdx) * 4 + int'(colIdx),
          expRow(code) * 4 + expCol(code));
    for (int i = 0; i < len - 1; i++) begin
      tick($urandom % 3);
      if (intrude && i == 5) writeCode(other);
      if (!toneOn || txEmptyEv) toneBad = 1;
      if (int'(rowIdx) != expRow(code) || int'(colIdx) != expCol(code)) idxBad = 1;
    end
    check(!toneBad, cp ? "R3 tone length held" : "R2 tone length held", int'(toneBad), 0);
    tick($urandom % 3);
    check(toneOn == 1'b0, cp ? "R3 tone ends on last tick" : "R2 tone ends on last tick",
          int'(toneOn), 0);
    for (int i = 0; i < len - 1; i++) begin
      tick($urandom % 3);
      if (intrude && i == 7) writeCode(other);
      if (toneOn || txEmptyEv) pauseBad = 1;
      if (int'(rowIdx) != expRow(code) || int'(colIdx) != expCol(code)) idxBad = 1;
    end
    check(!pauseBad, cp ? "R3 pause length held" : "R2 pause length held", int'(pauseBad), 0);
    if (intrude) check(!idxBad, "R7 intruding write ignored", int'(idxBad), 0);
    tick($urandom % 3);
    check(txEmptyEv == 1'b1, "R4 empty event at pause end", int'(txEmptyEv), 1);
    check(irqEv == ie, "R4 irq follows irqEn", int'(irqEv), int'(ie));
    @(negedge clk);
    check(txEmptyEv == 1'b0 && irqEv == 1'b0, "R4 events last one cycle",
          int'(txEmptyEv) + int'(irqEv), 0);
  endtask

  task automatic finish();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      finish();
    end
  end

  initial begin
    bit bad;
    void'($urandom(32'd1234));
    rstN = 0; wrEn = 0; wrCode = 0; msTick = 0; burstOffN = 0; cpMode = 0;
    toneOut = 1; singleSel = 0; colSel = 0; irqEn = 1;
    repeat (3) @(negedge clk);
    check(toneOn == 0 && rowEn == 0 && colEn == 0 && txEmptyEv == 0 && irqEv == 0,
          "R1 reset outputs", int'({toneOn, rowEn, colEn, txEmptyEv, irqEv}), 0);
    rstN = 1;
    @(negedge clk);
    check(toneOn == 0, "R1 idle after reset", int'(toneOn), 0);

    // directed bursts
    runBurst(5, 1'b0, 1'b1, 1'b0, 0);
    runBurst(0, 1'b1, 1'b0, 1'b0, 0);
    runBurst(13, 1'b0, 1'b1, 1'b1, 10);   // R7 intrusion
    runBurst(11, 1'b1, 1'b1, 1'b1, 2);    // R7 intrusion, long

    // R6: abandon mid-burst
    cpMode = 0;
    toneOut = 0;
    writeCode(7);
    repeat (4) tick(0);
    burstOffN = 1;
    @(negedge clk);
    check(toneOn == 0, "R6 burst abandoned when disabled", int'(toneOn), 0);
    burstOffN = 0;
    bad = 0;
    for (int i = 0; i < 2 * SHORT_LEN + 4; i++) begin
      tick(0);
      if (txEmptyEv || toneOn) bad = 1;
    end
    check(!bad, "R6 no empty event after abandon", int'(bad), 0);

    // random bursts
    for (int n = 0; n < 6; n++)
      runBurst(int'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 16));

    // random non-burst sweep
    burstOffN = 1;
    bad = 0;
    for (int n = 0; n < 60; n++) begin
      int code = (n < 16) ? n : int'($urandom % 16);
      bit to = 1'($urandom), ss = 1'($urandom), cs = 1'($urandom);
      bit er, ec;
      writeCode(code);
      toneOut = to; singleSel = ss; colSel = cs;
      msTick = 1'($urandom);
      @(negedge clk);
      msTick = 0;
      er = to && (!ss || !cs);
      ec = to && (!ss || cs);
      check(toneOn == to, "R5 toneOn follows toneOut", int'(toneOn), int'(to));
      check(rowEn == er && colEn == ec, "R9 group enables",
            int'({rowEn, colEn}), int'({er, ec}));
      check(int'(rowIdx) == expRow(code) && int'(colIdx) == expCol(code),
            "R8 code position", int'(rowIdx) * 4 + int'(colIdx),
            expRow(code) * 4 + expCol(code));
      if (txEmptyEv) bad = 1;
    end
    check(!bad, "R5 no empty event in non-burst mode", int'(bad), 0);
    finish();
  end

endmodule